// File: doc/BRIEF.md
# Paged Serial EEPROM Word Writer

This block stores a run of 16-bit words into a serial EEPROM that speaks the common SPI command set. A client hands it a starting word offset and a word count through a valid/ready request port, then streams the data words through a second valid/ready port. The block drives chip select, serial clock and serial data out itself, and samples the device's data output. The serial clock half-period is a parameter counted in system clocks.

Each burst starts with a ready check. The block reads the device status register until the busy bit clears, or gives up after a bounded number of attempts. It then sends a write-enable command in its own chip-select frame, and after that a write command that carries the byte address and as many data words as fit before the next page boundary. When a page fills up, the frame is closed and the whole check/enable/write sequence starts again for the words that remain. When the run is over, or when a fault stops it, a one-cycle done pulse reports the result on an error flag.

Top module: `eeprom_page_writer`

## Requirements
- R1: A request is rejected when the offset is not below WORD_SIZE, when the count is zero, or when the count is larger than WORD_SIZE minus the offset. A rejected request raises done with err=1 on the clock after it is accepted, and no chip-select frame is opened.
- R2: Each burst begins with one or more status frames. Each frame sends opcode 0x05 and then reads 8 status bits. The write sequence goes on only after a read in which status bit 0 (busy) is 0.
- R3: If MAX_POLL status reads in a row all show busy, the transfer ends with done and err=1, and no write command is sent.
- R4: Chip select goes high and then low again between any two commands. Write-enable (opcode 0x06) is sent alone in its own frame before every write frame.
- R5: With ADDR_BITS=8, bit 8 of the byte address travels as bit 3 (0x08) of the write opcode 0x02.
- R6: The write opcode is followed by the byte address, which is twice the current word offset. Opcode and address bits go out most significant bit first.
- R7: Each data word goes out with its bytes swapped, so that bits 7:0 reach the device first and land at the even byte address. Bits within a byte go out MSB first.
- R8: A burst ends after the word whose following word offset, times two, is a multiple of PAGE_BYTES. A run therefore uses one write frame per EEPROM page it touches.
- R9: While status bits are being read, the data-out line is held low. The device data is sampled while the serial clock is high, and the device changes it on the falling edge.
- R10: At the end of a run, done is high for exactly one cycle, err is 0 on success, chip select is high, the serial clock is low, and a new request is accepted on the following cycle.
- R11: Straight after reset, chip select is high, the serial clock and data-out are low, done is low and req_ready is high.
- R12: Every high phase of the serial clock lasts exactly DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and taking a request |
| req_offset | input | $clog2(WORD_SIZE+1) | First word offset |
| req_count | input | $clog2(WORD_SIZE+1) | Number of words |
| wdata_valid | input | 1 | Data word present |
| wdata_ready | output | 1 | Block takes a data word |
| wdata | input | 16 | Data word |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to device |
| spi_miso | input | 1 | Serial data from device |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Fault flag, valid with done |

## Verification
The assertions assume that the client keeps req_offset, req_count and wdata stable while their valid is high. They also assume that the data stream supplies exactly req_count words for an accepted request and nothing more. The bench meets both assumptions by driving the request fields and the valid in one falling-edge assignment, and by holding the valid for just one cycle. The data feeder indexes a prepared array, advances only on a handshake and stops feeding once done is seen. The device model changes its output only on falling serial clock edges, which fits the sampling point the shifter assumes.

// File: rtl/eew_pkg.sv
package eew_pkg;

  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_A8    = 8'h08;

  typedef enum logic [3:0] {
    W_IDLE, W_PREP, W_POLL_OP, W_POLL_RD, W_SB_HI, W_SB_LO,
    W_WREN, W_WR_OP, W_WR_ADR, W_FETCH, W_DATA, W_END
  } wst_e;

  // Request lies fully inside the device
  function automatic logic req_in_range(int unsigned off, int unsigned cnt,
                                        int unsigned size);
    return (off < size) && (cnt != 0) && (cnt <= size - off);
  endfunction

  function automatic logic [15:0] swap_bytes(logic [15:0] w);
    return {w[7:0], w[15:8]};
  endfunction

  function automatic logic [31:0] byte_addr(int unsigned word);
    return 32'(word << 1);
  endfunction

  // Word begins a new EEPROM page (page size is a power of two)
  function automatic logic at_page_start(int unsigned word, int unsigned page_bytes);
    return ((word << 1) & (page_bytes - 1)) == 0;
  endfunction

endpackage

// File: rtl/eew_tick.sv
module eew_tick #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + CW'(1);
  end

  generate
    if (DIV > 1) begin : g_spacing
      // R12
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/eew_shifter.sv
module eew_shifter #(
  parameter int DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        start,
  input  logic        rx_mode,
  input  logic [4:0]  nbits,
  input  logic [15:0] tx_word,
  input  logic        miso,
  output logic        sck,
  output logic        mosi,
  output logic        busy,
  output logic        fin,
  output logic [7:0]  rx_byte
);
  localparam int HLW = $clog2(DIV + 1) + 1;

  logic [15:0]    aligned;
  logic [14:0]    shreg;
  logic [4:0]     cnt;
  logic           rxm;
  logic [HLW-1:0] hl;

  assign aligned = tx_word << (5'd16 - nbits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; sck <= 1'b0; mosi <= 1'b0; fin <= 1'b0;
      cnt <= '0; shreg <= '0; rxm <= 1'b0; rx_byte <= '0;
    end else begin
      fin <= 1'b0;
      if (start && !busy) begin
        busy    <= 1'b1;
        cnt     <= nbits;
        shreg   <= aligned[14:0];
        rxm     <= rx_mode;
        mosi    <= rx_mode ? 1'b0 : aligned[15];
        rx_byte <= '0;
      end else if (busy && tick) begin
        if (!sck) begin
          sck <= 1'b1;
        end else begin
          sck     <= 1'b0;
          rx_byte <= {rx_byte[6:0], miso};
          shreg   <= {shreg[13:0], 1'b0};
          cnt     <= cnt - 5'd1;
          if (cnt == 5'd1) begin
            busy <= 1'b0;
            fin  <= 1'b1;
            mosi <= 1'b0;
          end else begin
            mosi <= rxm ? 1'b0 : shreg[14];
          end
        end
      end
    end
  end

  // cycles the serial clock has been high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hl <= '0;
    else if (sck) hl <= hl + HLW'(1);
    else          hl <= '0;
  end

  // R9
  rx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rxm) |-> !mosi);

  // R12
  half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck) |-> (hl == HLW'(DIV)));

  // R10
  idle_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import eew_pkg::*;
#(
  parameter int WORD_SIZE  = 256,
  parameter int ADDR_BITS  = 8,
  parameter int PAGE_BYTES = 16,
  parameter int DIV        = 2,
  parameter int MAX_POLL   = 8,
  localparam int WW        = $clog2(WORD_SIZE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [WW-1:0] req_offset,
  input  logic [WW-1:0] req_count,
  input  logic          wdata_valid,
  output logic          wdata_ready,
  input  logic [15:0]   wdata,
  output logic          spi_cs_n,
  output logic          spi_sck,
  output logic          spi_mosi,
  input  logic          spi_miso,
  output logic          done,
  output logic          err
);
  localparam int PW  = $clog2(MAX_POLL + 1);
  localparam int BAW = ADDR_BITS + 1;

  wst_e           st, ret;
  logic [WW-1:0]  cur, left;
  logic [PW-1:0]  polls;
  logic [15:0]    word_q;
  logic           err_q, launched;

  logic           tick;
  logic           sh_start, sh_rx, sh_busy, sh_fin;
  logic [4:0]     sh_n;
  logic [15:0]    sh_tx;
  logic [7:0]     sh_rxb;
  logic           shift_state;
  logic [BAW-1:0] ba;
  logic           a8;

  // named events
  logic req_fire, req_bad, stat_ready, poll_exhausted, page_cut, last_word;

  eew_tick #(.DIV(DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

  eew_shifter #(.DIV(DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(sh_start), .rx_mode(sh_rx),
    .nbits(sh_n), .tx_word(sh_tx), .miso(spi_miso), .sck(spi_sck),
    .mosi(spi_mosi), .busy(sh_busy), .fin(sh_fin), .rx_byte(sh_rxb));

  assign ba             = BAW'(byte_addr(32'(cur)));
  assign a8             = (ADDR_BITS == 8) && ba[8];
  assign req_fire       = req_valid && req_ready;
  assign req_bad        = !req_in_range(32'(req_offset), 32'(req_count), WORD_SIZE);
  assign stat_ready     = !sh_rxb[0];
  assign poll_exhausted = (polls == PW'(MAX_POLL - 1));
  assign page_cut       = at_page_start(32'(cur) + 32'd1, PAGE_BYTES);
  assign last_word      = (left == WW'(1));

  always_comb begin
    sh_rx = 1'b0;
    sh_n  = 5'd8;
    sh_tx = 16'h0000;
    case (st)
      W_POLL_OP: sh_tx = {8'h00, OP_RDSR};
      W_POLL_RD: sh_rx = 1'b1;
      W_WREN:    sh_tx = {8'h00, OP_WREN};
      W_WR_OP:   sh_tx = {8'h00, OP_WRITE | (a8 ? OP_A8 : 8'h00)};
      W_WR_ADR: begin
        sh_n  = 5'(ADDR_BITS);
        sh_tx = 16'(ba[ADDR_BITS-1:0]);
      end
      W_DATA: begin
        sh_n  = 5'd16;
        sh_tx = swap_bytes(word_q);
      end
      default: ;
    endcase
    shift_state = st inside {W_POLL_OP, W_POLL_RD, W_WREN, W_WR_OP, W_WR_ADR, W_DATA};
    sh_start    = shift_state && !launched;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= W_IDLE; ret <= W_IDLE;
      cur <= '0; left <= '0; polls <= '0; word_q <= '0;
      err_q <= 1'b0; launched <= 1'b0;
    end else begin
      if (sh_start) launched <= 1'b1;
      if (sh_fin)   launched <= 1'b0;
      case (st)
        W_IDLE: if (req_fire) begin
          cur   <= req_offset;
          left  <= req_count;
          polls <= '0;
          err_q <= req_bad;
          st    <= req_bad ? W_END : W_PREP;
        end
        W_PREP:    if (tick) st <= W_POLL_OP;
        W_POLL_OP: if (sh_fin) st <= W_POLL_RD;
        W_POLL_RD: if (sh_fin) begin
          if (stat_ready) begin
            ret <= W_WREN;
            st  <= W_SB_HI;
          end else if (poll_exhausted) begin
            err_q <= 1'b1;
            st    <= W_END;
          end else begin
            polls <= polls + PW'(1);
            ret   <= W_POLL_OP;
            st    <= W_SB_HI;
          end
        end
        W_SB_HI: if (tick) st <= W_SB_LO;
        W_SB_LO: if (tick) st <= ret;
        W_WREN: if (sh_fin) begin
          ret <= W_WR_OP;
          st  <= W_SB_HI;
        end
        W_WR_OP:  if (sh_fin) st <= W_WR_ADR;
        W_WR_ADR: if (sh_fin) st <= W_FETCH;
        W_FETCH: if (wdata_valid) begin
          word_q <= wdata;
          st     <= W_DATA;
        end
        W_DATA: if (sh_fin) begin
          cur  <= cur + WW'(1);
          left <= left - WW'(1);
          if (last_word) begin
            st <= W_END;
          end else if (page_cut) begin
            polls <= '0;
            ret   <= W_POLL_OP;
            st    <= W_SB_HI;
          end else begin
            st <= W_FETCH;
          end
        end
        W_END:   st <= W_IDLE;
        default: st <= W_IDLE;
      endcase
    end
  end

  assign req_ready   = (st == W_IDLE);
  assign wdata_ready = (st == W_FETCH);
  assign spi_cs_n    = st inside {W_IDLE, W_SB_HI, W_END};
  assign done        = (st == W_END);
  assign err         = done && err_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  end_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (spi_cs_n && !spi_sck));

  // R4
  cs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> !sh_busy);

  // R1
  idle_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> spi_cs_n);

  // R8
  data_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdata_ready |-> (!spi_cs_n && !sh_busy));

  // R3
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == W_POLL_RD) |-> (polls <= PW'(MAX_POLL - 1)));
endmodule

// File: tb/eeprom_page_writer_test.sv
module eeprom_page_writer_test;
  localparam int WS = 256;
  localparam int AB = 8;
  localparam int PB = 16;
  localparam int DV = 2;
  localparam int MP = 8;
  localparam int WW = $clog2(WS + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic          req_valid = 1'b0, req_ready;
  logic [WW-1:0] req_offset = '0, req_count = '0;
  logic          wdata_valid = 1'b0, wdata_ready;
  logic [15:0]   wdata;
  logic          spi_cs_n, spi_sck, spi_mosi;
  logic          spi_miso = 1'b0;
  logic          done, err;

  eeprom_page_writer #(.WORD_SIZE(WS), .ADDR_BITS(AB), .PAGE_BYTES(PB),
                       .DIV(DV), .MAX_POLL(MP)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_offset(req_offset), .req_count(req_count), .wdata_valid(wdata_valid),
    .wdata_ready(wdata_ready), .wdata(wdata), .spi_cs_n(spi_cs_n),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .done(done), .err(err));

  // ---------------- behavioural EEPROM ----------------
  byte unsigned mem  [512];
  byte unsigned expm [512];
  int   bitcnt = 0, nbytes = 0;
  logic [7:0] opc = 8'h00, stat = 8'h00, dbyte = 8'h00, abyte = 8'h00;
  bit   wel = 1'b0;
  int   busy_left = 0, busy_len = 0;
  int   rdsr_n = 0, wren_n = 0, wr_n = 0, csfall_n = 0;
  int   quiet_bad = 0, nowel_n = 0, hi_bad = 0, hc = 0;

  always @(negedge spi_cs_n) begin
    bitcnt = 0; opc = 8'h00; nbytes = 0; csfall_n++;
  end

  always @(posedge spi_sck) if (!spi_cs_n) begin
    if (bitcnt < 8) begin
      opc = {opc[6:0], spi_mosi};
      if (bitcnt == 7) begin
        if (opc == 8'h05) begin
          rdsr_n++;
          stat = {6'b0, wel, busy_left > 0};
        end else if (opc == 8'h06) begin
          wel = 1'b1; wren_n++;
        end else if ((opc & 8'hF7) == 8'h02) begin
          wr_n++;
        end
      end
    end else if (opc == 8'h05) begin
      if (spi_mosi) quiet_bad++;
    end else if ((opc & 8'hF7) == 8'h02) begin
      if (bitcnt < 8 + AB) abyte = {abyte[6:0], spi_mosi};
      else begin
        dbyte = {dbyte[6:0], spi_mosi};
        if ((bitcnt - 8 - AB) % 8 == 7) begin
          int a, pg, idx;
          a   = {23'd0, opc[3], abyte};
          pg  = a - (a % PB);
          idx = pg + ((a % PB) + nbytes) % PB;
          if (wel) mem[idx] = dbyte;
          else     nowel_n++;
          nbytes++;
        end
      end
    end
    bitcnt++;
  end

  always @(negedge spi_sck) if (!spi_cs_n && bitcnt >= 8 && opc == 8'h05) begin
    spi_miso = stat[7];
    stat = {stat[6:0], 1'b0};
  end

  always @(posedge spi_cs_n) begin
    if (opc == 8'h05 && bitcnt >= 8 && busy_left > 0) busy_left--;
    if ((opc & 8'hF7) == 8'h02 && nbytes > 0) begin
      wel = 1'b0; busy_left = busy_len;
    end
  end

  // serial clock high-time monitor (R12)
  always @(negedge clk) begin
    if (spi_sck) hc++;
    else if (hc != 0) begin
      if (hc != DV) hi_bad++;
      hc = 0;
    end
  end

  // ---------------- data feeder ----------------
  logic [15:0] words [0:255];
  int widx = 0;
  bit feeding = 1'b0;
  assign wdata = words[widx[7:0]];
  always @(posedge clk) if (wdata_valid && wdata_ready) widx <= widx + 1;
  always @(negedge clk) wdata_valid <= feeding && ($urandom_range(3) != 0);

  // ---------------- checking ----------------
  int vecs = 0, bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int exp_bursts(int off, int cnt);
    return ((off + cnt - 1) * 2) / PB - (off * 2) / PB + 1;
  endfunction

  task automatic clear_counts();
    rdsr_n = 0; wren_n = 0; wr_n = 0; quiet_bad = 0; nowel_n = 0; hi_bad = 0;
  endtask

  task automatic do_req(input int off, input int cnt);
    @(negedge clk);
    req_offset = WW'(off); req_count = WW'(cnt); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 100000) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic run_ok(input int off, input int cnt, input int bl);
    int b, mism;
    b = exp_bursts(off, cnt);
    busy_len = bl; busy_left = bl;
    clear_counts();
    for (int i = 0; i < cnt; i++) begin
      words[i] = 16'($urandom);
      expm[(off + i) * 2]     = words[i][7:0];
      expm[(off + i) * 2 + 1] = words[i][15:8];
    end
    widx = 0; feeding = 1'b1;
    do_req(off, cnt);
    wait_done();
    feeding = 1'b0;
    chk(done && !err, "R10 done without error", {30'd0, done, err}, 2);
    chk(spi_cs_n && !spi_sck, "R10 lines idle at done", {30'd0, spi_cs_n, spi_sck}, 2);
    mism = 0;
    for (int i = 0; i < 512; i++) if (mem[i] != expm[i]) mism++;
    chk(mism == 0, "R7 byte image (R5 upper half, R6 address)", mism, 0);
    chk(wr_n == b, "R8 write frames per run", wr_n, b);
    chk(wren_n == b, "R4 enable frames per run", wren_n, b);
    chk(nowel_n == 0, "R4 data bytes without enable", nowel_n, 0);
    chk(rdsr_n == b * (bl + 1), "R2 status reads per run", rdsr_n, b * (bl + 1));
    chk(quiet_bad == 0, "R9 data-out high while reading", quiet_bad, 0);
    chk(hi_bad == 0, "R12 clock high time", hi_bad, 0);
    chk(widx == cnt, "R10 words consumed", widx, cnt);
    @(negedge clk);
    chk(!done && req_ready, "R10 single-cycle done then ready", {30'd0, done, req_ready}, 1);
  endtask

  task automatic run_reject(input int off, input int cnt);
    int c0;
    c0 = csfall_n;
    do_req(off, cnt);
    chk(done && err, "R1 rejected request flags error", {30'd0, done, err}, 3);
    chk(csfall_n == c0, "R1 no frame opened", csfall_n - c0, 0);
    @(negedge clk);
    chk(!done && req_ready, "R1 back to idle", {30'd0, done, req_ready}, 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(spi_cs_n && !spi_sck && !spi_mosi && req_ready && !done,
        "R11 reset state", {27'd0, spi_cs_n, spi_sck, spi_mosi, req_ready, done}, 5'b10010);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_reject(256, 1);
    run_reject(0, 0);
    run_reject(250, 7);

    run_ok(0, 1, 0);
    run_ok(7, 2, 1);      // crosses a page after one word
    run_ok(120, 16, 2);   // crosses into the upper half of the array
    run_ok(250, 6, 0);    // exactly fills to the last word
    run_ok(255, 1, 3);

    for (int k = 0; k < 12; k++) begin
      int off, room, cnt;
      off  = $urandom_range(WS - 1);
      room = WS - off;
      if (room > 40) room = 40;
      cnt  = 1 + $urandom_range(room - 1);
      run_ok(off, cnt, $urandom_range(3));
    end

    // R3 device stays busy
    busy_len = 100000; busy_left = 100000;
    clear_counts();
    for (int i = 0; i < 512; i++) expm[i] = mem[i];
    widx = 0; feeding = 1'b1;
    do_req(10, 4);
    wait_done();
    feeding = 1'b0;
    chk(done && err, "R3 busy timeout flags error", {30'd0, done, err}, 3);
    chk(rdsr_n == MP, "R3 status reads before giving up", rdsr_n, MP);
    chk(wr_n == 0 && wren_n == 0, "R3 no enable or write sent", wr_n + wren_n, 0);
    chk(spi_cs_n && !spi_sck, "R10 lines idle after fault", {30'd0, spi_cs_n, spi_sck}, 2);
    @(negedge clk);
    chk(!done && req_ready, "R10 ready after fault", {30'd0, done, req_ready}, 1);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule